// File: doc/BRIEF.md
# Masked-Configuration GPIO Bank

This block runs a bank of 32 general-purpose I/O lines behind a small register port. The port has a word address, a write strobe, a read strobe, write data and read data. Read data appears one cycle after the read strobe. Each line is either a plain GPIO or is handed to one of seven peripheral functions. The block drives a per-line output enable, output value and function code toward the pads.

Per-line settings are never addressed one line at a time. Software first writes a line-select mask. A single write to the shared settings register then lands on every selected line. Output bits change through separate write-one set and write-one clear registers, so no read-modify-write is needed. Inputs are synchronised, and each line can flag a falling edge, a rising edge, either edge, a low level or a high level. Events collect in a clear-on-read status word, and an enable mask gates them onto one interrupt line. Pull, filter, open-drain, Schmitt and drive-strength fields are only stored and read back. The freeze word is handled the same way.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, every line is a GPIO input with all stored setting fields at 0. The select mask, output bits, interrupt enables and status bits are 0, so pad_oe, pad_out, pad_func, irq and reg_rdata are all 0.
- R2: Registers sit at word addresses: 0 select mask, 1 settings, 2 pin level, 3 lock status, 4 output set, 5 output clear, 6 output readback, 8 interrupt enable, 9 interrupt disable, 10 interrupt mask readback, 11 interrupt status, 15 freeze. reg_rdata holds the addressed value in the cycle after reg_re is sampled high, and 0 otherwise. Addresses 7, 12, 13 and 14 read 0 and ignore writes. Write-only registers read 0.
- R3: The select mask reads back as written. A settings write changes the stored settings of exactly the lines whose mask bit is 1. Every other line keeps its settings.
- R4: The settings word layout is: function in [2:0] (0 is GPIO, 1 to 7 are peripherals), output direction in bit 8 (1 is output), pull-up in bit 9, pull-down in bit 10, filter enable in bit 12, slow-filter select in bit 13, open-drain in bit 14, Schmitt disable in bit 15, drive strength in [17:16] and event select in [26:24]. All other bits are not stored and read 0.
- R5: A settings read returns the settings word of the lowest-numbered line whose mask bit is 1, or 0 when the mask is empty.
- R6: Writing word 4 sets each output bit whose written bit is 1. Writing word 5 clears each output bit whose written bit is 1. Written 0 bits leave their output bits alone. Word 6 reads the current output bits.
- R7: pad_oe[i] is 1 only when line i has function 0 and direction 1. pad_out[i] equals output bit i when pad_oe[i] is 1 and is 0 otherwise. pad_func[3i+2:3i] carries the function of line i.
- R8: Word 2 returns pin_in after two synchronising flops: a level applied before a clock edge is readable by a read strobe sampled two edges later.
- R9: On the synchronised input, event select 0 flags a falling edge, 1 a rising edge, 2 either edge, 3 every cycle the line is low, and 4 every cycle it is high. Codes 5 to 7 never flag.
- R10: Writing 1 bits to word 8 sets interrupt mask bits and writing 1 bits to word 9 clears them. Written 0 bits change nothing, and word 10 reads the mask.
- R11: A flagged event sets its status bit, which then stays set until word 11 is read. That read returns the status and clears it, except that an event flagged in the same cycle as the read stays set.
- R12: irq is 1 exactly when some line has both its status bit and its interrupt mask bit at 1.
- R13: Word 3 (lock status) always reads 0. Word 15 stores the full written word and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_re |
| pin_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Per-line output enable |
| pad_out | output | 32 | Per-line driven value |
| pad_func | output | 96 | Per-line 3-bit function code |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the lowest-selected-line readback with several lines selected, with one line selected and with none. A design that scanned from the top would return the wrong line's word, and one that forgot the empty case would return stale data. It drives the same line through the input pins and checks that a peripheral function with its direction bit set never enables the pad. It checks that a level-sensitive line re-flags in the very cycle its status is read. A design that let the clear win would lose a continuing low or high level. It walks every event-select code, including an unused one, over chosen pin transitions. It also masks and unmasks a pending status bit and watches irq follow the mask alone.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NLINES  = 32;
    localparam int DW      = 32;
    localparam int AW      = 4;
    localparam int FUNC_W  = 3;
    localparam logic [DW-1:0] CFG_USED = 32'h0703_F707;

    typedef enum logic [AW-1:0] {
        RG_MASK  = 4'd0,
        RG_CFG   = 4'd1,
        RG_PIN   = 4'd2,
        RG_LOCK  = 4'd3,
        RG_SET   = 4'd4,
        RG_CLR   = 4'd5,
        RG_ODAT  = 4'd6,
        RG_IEN   = 4'd8,
        RG_IDIS  = 4'd9,
        RG_IMSK  = 4'd10,
        RG_ISTAT = 4'd11,
        RG_FRZ   = 4'd15
    } reg_sel_e;

    typedef enum logic [2:0] {
        EV_FALL = 3'd0,
        EV_RISE = 3'd1,
        EV_BOTH = 3'd2,
        EV_LOW  = 3'd3,
        EV_HIGH = 3'd4,
        EV_NA5  = 3'd5,
        EV_NA6  = 3'd6,
        EV_NA7  = 3'd7
    } ev_sel_e;

    typedef struct packed {
        logic [2:0]        evsel;
        logic [1:0]        drive;
        logic              schmitt_off;
        logic              open_drain;
        logic              slow_filt;
        logic              filt_en;
        logic              pull_dn;
        logic              pull_up;
        logic              dir_out;
        logic [FUNC_W-1:0] func;
    } line_cfg_t;

    function automatic line_cfg_t cfg_unpack(input logic [DW-1:0] w);
        line_cfg_t c;
        c.func        = w[2:0];
        c.dir_out     = w[8];
        c.pull_up     = w[9];
        c.pull_dn     = w[10];
        c.filt_en     = w[12];
        c.slow_filt   = w[13];
        c.open_drain  = w[14];
        c.schmitt_off = w[15];
        c.drive       = w[17:16];
        c.evsel       = w[26:24];
        return c;
    endfunction

    function automatic logic [DW-1:0] cfg_pack(input line_cfg_t c);
        logic [DW-1:0] w;
        w        = '0;
        w[2:0]   = c.func;
        w[8]     = c.dir_out;
        w[9]     = c.pull_up;
        w[10]    = c.pull_dn;
        w[12]    = c.filt_en;
        w[13]    = c.slow_filt;
        w[14]    = c.open_drain;
        w[15]    = c.schmitt_off;
        w[17:16] = c.drive;
        w[26:24] = c.evsel;
        return w;
    endfunction

    function automatic logic ev_hit(input ev_sel_e s, input logic cur, input logic prv);
        case (s)
            EV_FALL: return prv & ~cur;
            EV_RISE: return ~prv & cur;
            EV_BOTH: return prv ^ cur;
            EV_LOW:  return ~cur;
            EV_HIGH: return cur;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_bank_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N-1:0]                sel_mask,
    input  logic                        cfg_we,
    input  logic [DW-1:0]               cfg_wdata,
    output logic [DW-1:0]               cfg_rword,
    output logic [N-1:0][FUNC_W-1:0]    func_v,
    output logic [N-1:0]                dir_v,
    output logic [N-1:0][2:0]           evsel_v
);

    line_cfg_t cfg_q [N];
    line_cfg_t wr_cfg;

    assign wr_cfg = cfg_unpack(cfg_wdata);

    for (genvar gi = 0; gi < N; gi++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[gi] <= '0;
            else if (cfg_we && sel_mask[gi])
                cfg_q[gi] <= wr_cfg;
        end

        assign func_v[gi]  = cfg_q[gi].func;
        assign dir_v[gi]   = cfg_q[gi].dir_out;
        assign evsel_v[gi] = cfg_q[gi].evsel;

        // R3: unselected lines keep their settings across a settings write
        a_r3_unselected_hold: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && !sel_mask[gi]) |=> $stable(cfg_q[gi]));

        // R4: selected lines take exactly the stored field bits of the word
        a_r4_selected_take: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && sel_mask[gi]) |=> (cfg_pack(cfg_q[gi]) == ($past(cfg_wdata) & CFG_USED)));
    end

    // Lowest selected line wins: scan downward so the last hit is the lowest index
    always_comb begin
        cfg_rword = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel_mask[i])
                cfg_rword = cfg_pack(cfg_q[i]);
        end
    end

    // R5: an empty selection reads back 0
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (sel_mask == '0) |-> (cfg_rword == '0));

endmodule

// File: rtl/gpio_out_drive.sv
module gpio_out_drive
    import gpio_bank_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        set_we,
    input  logic                        clr_we,
    input  logic [N-1:0]                wbits,
    input  logic [N-1:0][FUNC_W-1:0]    func_v,
    input  logic [N-1:0]                dir_v,
    output logic [N-1:0]                out_q,
    output logic [N-1:0]                pad_oe,
    output logic [N-1:0]                pad_out,
    output logic [N*FUNC_W-1:0]         pad_func
);

    logic [N-1:0] set_bits;
    logic [N-1:0] clr_bits;

    assign set_bits = set_we ? wbits : '0;
    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= (out_q | set_bits) & ~clr_bits;
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_pad
        assign pad_oe[gi]                      = (func_v[gi] == '0) && dir_v[gi];
        assign pad_out[gi]                     = pad_oe[gi] & out_q[gi];
        assign pad_func[gi*FUNC_W +: FUNC_W]   = func_v[gi];

        // R7: a line in a peripheral function never has its pad enabled here
        a_r7_oe_gpio_only: assert property (@(posedge clk) disable iff (rst)
            pad_oe[gi] |-> (pad_func[gi*FUNC_W +: FUNC_W] == '0));
    end

    // R6: written ones take effect, written zeros leave bits alone
    a_r6_set_ones: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((out_q & $past(wbits)) == $past(wbits)));
    a_r6_set_zeros_keep: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits))));
    a_r6_clr_ones: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((out_q & $past(wbits)) == '0));
    a_r6_clr_zeros_keep: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits))));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_bank_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        pin_in,
    input  logic [N-1:0][2:0]   evsel_v,
    input  logic                en_we,
    input  logic                dis_we,
    input  logic                stat_rd,
    input  logic [N-1:0]        wbits,
    output logic [N-1:0]        pin_sync,
    output logic [N-1:0]        imr_q,
    output logic [N-1:0]        isr_q,
    output logic                irq
);

    logic [N-1:0] sync1_q;
    logic [N-1:0] sync2_q;
    logic [N-1:0] prev_q;
    logic [N-1:0] ev_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign pin_sync = sync2_q;

    for (genvar gi = 0; gi < N; gi++) begin : g_det
        assign ev_vec[gi] = ev_hit(ev_sel_e'(evsel_v[gi]), sync2_q[gi], prev_q[gi]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q <= '0;
            isr_q <= '0;
        end else begin
            imr_q <= (imr_q | (en_we ? wbits : '0)) & ~(dis_we ? wbits : '0);
            isr_q <= (stat_rd ? '0 : isr_q) | ev_vec;
        end
    end

    assign irq = |(isr_q & imr_q);

    // R10: enable sets, disable clears, zeros change nothing
    a_r10_enable_sets: assert property (@(posedge clk) disable iff (rst)
        en_we |=> ((imr_q & $past(wbits)) == $past(wbits)));
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
        dis_we |=> ((imr_q & $past(wbits)) == '0));
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!en_we && !dis_we) |=> $stable(imr_q));

    // R11: status is sticky without a read, and a read leaves only fresh events
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((isr_q & $past(isr_q)) == $past(isr_q)));
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> ((isr_q & ~$past(ev_vec)) == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           reg_addr,
    input  logic                    reg_we,
    input  logic                    reg_re,
    input  logic [DW-1:0]           reg_wdata,
    output logic [DW-1:0]           reg_rdata,
    input  logic [N-1:0]            pin_in,
    output logic [N-1:0]            pad_oe,
    output logic [N-1:0]            pad_out,
    output logic [N*FUNC_W-1:0]     pad_func,
    output logic                    irq
);

    reg_sel_e                   sel;
    logic [N-1:0]               mask_q;
    logic [DW-1:0]              frz_q;
    logic [DW-1:0]              rd_mux;
    logic [DW-1:0]              rdata_q;
    logic [DW-1:0]              cfg_rword;
    logic [N-1:0][FUNC_W-1:0]   func_v;
    logic [N-1:0]               dir_v;
    logic [N-1:0][2:0]          evsel_v;
    logic [N-1:0]               out_q;
    logic [N-1:0]               pin_sync;
    logic [N-1:0]               imr_q;
    logic [N-1:0]               isr_q;
    logic                       wr_mask, wr_cfg, wr_set, wr_clr;
    logic                       wr_ien, wr_idis, wr_frz, rd_stat;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_mask = reg_we && (sel == RG_MASK);
    assign wr_cfg  = reg_we && (sel == RG_CFG);
    assign wr_set  = reg_we && (sel == RG_SET);
    assign wr_clr  = reg_we && (sel == RG_CLR);
    assign wr_ien  = reg_we && (sel == RG_IEN);
    assign wr_idis = reg_we && (sel == RG_IDIS);
    assign wr_frz  = reg_we && (sel == RG_FRZ);
    assign rd_stat = reg_re && (sel == RG_ISTAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            frz_q  <= '0;
        end else begin
            if (wr_mask) mask_q <= reg_wdata[N-1:0];
            if (wr_frz)  frz_q  <= reg_wdata;
        end
    end

    gpio_cfg_bank #(.N(N)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .sel_mask  (mask_q),
        .cfg_we    (wr_cfg),
        .cfg_wdata (reg_wdata),
        .cfg_rword (cfg_rword),
        .func_v    (func_v),
        .dir_v     (dir_v),
        .evsel_v   (evsel_v)
    );

    gpio_out_drive #(.N(N)) u_out (
        .clk      (clk),
        .rst      (rst),
        .set_we   (wr_set),
        .clr_we   (wr_clr),
        .wbits    (reg_wdata[N-1:0]),
        .func_v   (func_v),
        .dir_v    (dir_v),
        .out_q    (out_q),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pad_func (pad_func)
    );

    gpio_irq_unit #(.N(N)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .evsel_v  (evsel_v),
        .en_we    (wr_ien),
        .dis_we   (wr_idis),
        .stat_rd  (rd_stat),
        .wbits    (reg_wdata[N-1:0]),
        .pin_sync (pin_sync),
        .imr_q    (imr_q),
        .isr_q    (isr_q),
        .irq      (irq)
    );

    always_comb begin
        case (sel)
            RG_MASK:  rd_mux = DW'(mask_q);
            RG_CFG:   rd_mux = cfg_rword;
            RG_PIN:   rd_mux = DW'(pin_sync);
            RG_ODAT:  rd_mux = DW'(out_q);
            RG_IMSK:  rd_mux = DW'(imr_q);
            RG_ISTAT: rd_mux = DW'(isr_q);
            RG_FRZ:   rd_mux = frz_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else
            rdata_q <= reg_re ? rd_mux : '0;
    end

    assign reg_rdata = rdata_q;

    // R1: the cycle after reset the pads and interrupt are quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && pad_func == '0 && !irq && reg_rdata == '0));

    // R2: no read strobe, no read data
    a_r2_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !reg_re |=> (reg_rdata == '0));

    // R3: mask write lands as written
    a_r3_mask_write: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_q == $past(reg_wdata[N-1:0])));

    // R13: freeze word stores the full write
    a_r13_freeze_store: assert property (@(posedge clk) disable iff (rst)
        wr_frz |=> (frz_q == $past(reg_wdata)));

endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;
    logic [95:0] pad_func;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit armed = 0;

    always #2.5 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_func(pad_func), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_cfg [32];
    logic [31:0] m_mask, m_out, m_imr, m_isr, m_s1, m_s2, m_prev, m_frz, m_rdata;

    always @(posedge clk) begin
        logic [31:0] ev;
        logic [31:0] rd;
        logic [31:0] nisr;
        armed <= 1'b1;
        if (rst) begin
            for (int i = 0; i < 32; i++) m_cfg[i] = '0;
            m_mask = '0; m_out = '0; m_imr = '0; m_isr = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_frz = '0; m_rdata = '0;
        end else begin
            ev = '0;
            for (int i = 0; i < 32; i++) begin
                case (m_cfg[i][26:24])
                    3'd0: ev[i] = m_prev[i] && !m_s2[i];
                    3'd1: ev[i] = !m_prev[i] && m_s2[i];
                    3'd2: ev[i] = m_prev[i] != m_s2[i];
                    3'd3: ev[i] = !m_s2[i];
                    3'd4: ev[i] = m_s2[i];
                    default: ev[i] = 1'b0;
                endcase
            end
            rd = '0;
            if (reg_re) begin
                case (reg_addr)
                    4'd0:  rd = m_mask;
                    4'd1:  for (int i = 31; i >= 0; i--) if (m_mask[i]) rd = m_cfg[i];
                    4'd2:  rd = m_s2;
                    4'd6:  rd = m_out;
                    4'd10: rd = m_imr;
                    4'd11: rd = m_isr;
                    4'd15: rd = m_frz;
                    default: rd = '0;
                endcase
            end
            nisr = ((reg_re && reg_addr == 4'd11) ? 32'h0 : m_isr) | ev;
            if (reg_we) begin
                case (reg_addr)
                    4'd0:  m_mask = reg_wdata;
                    4'd1:  for (int i = 0; i < 32; i++) if (m_mask[i]) m_cfg[i] = reg_wdata & 32'h0703_F707;
                    4'd4:  m_out = m_out | reg_wdata;
                    4'd5:  m_out = m_out & ~reg_wdata;
                    4'd8:  m_imr = m_imr | reg_wdata;
                    4'd9:  m_imr = m_imr & ~reg_wdata;
                    4'd15: m_frz = reg_wdata;
                    default: ;
                endcase
            end
            m_isr   = nisr;
            m_rdata = rd;
            m_prev  = m_s2;
            m_s2    = m_s1;
            m_s1    = pin_in;
        end
    end

    task automatic chk(input logic [127:0] got, input logic [127:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] e_oe, e_out;
        logic [95:0] e_fn;
        if (armed) begin
            for (int i = 0; i < 32; i++) begin
                e_oe[i] = (m_cfg[i][2:0] == 3'd0) && m_cfg[i][8];
                e_out[i] = e_oe[i] && m_out[i];
                e_fn[i*3 +: 3] = m_cfg[i][2:0];
            end
            chk(reg_rdata, m_rdata, "R2 rdata vs model");
            chk(pad_oe, e_oe, "R7 pad_oe vs model");
            chk(pad_out, e_out, "R7 pad_out vs model");
            chk(pad_func, e_fn, "R7 pad_func vs model");
            chk(irq, |(m_isr & m_imr), "R12 irq vs model");
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        v = reg_rdata;
        reg_re = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(pad_oe, 0, "R1 pad_oe after reset");
        chk(pad_out, 0, "R1 pad_out after reset");
        chk(pad_func, 0, "R1 pad_func after reset");
        chk(irq, 0, "R1 irq after reset");
        rd(4'd0, v);  chk(v, 0, "R1 mask after reset");
        rd(4'd10, v); chk(v, 0, "R1 imask after reset");
        rd(4'd6, v);  chk(v, 0, "R1 outputs after reset");
        rd(4'd1, v);  chk(v, 0, "R1 settings after reset");

        // R6/R7 outputs on lines 4..7
        wr(4'd0, 32'h0000_00F0);
        wr(4'd1, 32'h0000_0100);
        wr(4'd4, 32'hFFFF_FFFF);
        chk(pad_oe, 32'hF0, "R7 oe on gpio outputs");
        chk(pad_out, 32'hF0, "R7 out on gpio outputs");
        rd(4'd6, v);  chk(v, 32'hFFFF_FFFF, "R6 set all");
        wr(4'd5, 32'h0000_0030);
        rd(4'd6, v);  chk(v, 32'hFFFF_FFCF, "R6 clear two");
        chk(pad_out, 32'hC0, "R7 out after clear");
        wr(4'd4, 32'h0);
        wr(4'd5, 32'h0);
        rd(4'd6, v);  chk(v, 32'hFFFF_FFCF, "R6 zero bits no effect");

        // R3/R4/R5 settings
        wr(4'd0, 32'h0001_0000);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, v);  chk(v, 32'h0703_F707, "R4 stored field layout");
        chk(pad_func[50:48], 3'd7, "R7 function code line 16");
        chk(pad_oe, 32'hF0, "R7 peripheral with dir set not enabled");
        rd(4'd0, v);  chk(v, 32'h0001_0000, "R3 mask readback");
        wr(4'd0, 32'h0001_0010);
        rd(4'd1, v);  chk(v, 32'h0000_0100, "R5 lowest selected line");
        wr(4'd0, 32'h0);
        rd(4'd1, v);  chk(v, 32'h0, "R5 empty mask reads 0");
        wr(4'd1, 32'h0000_0005);
        wr(4'd0, 32'h0000_0010);
        rd(4'd1, v);  chk(v, 32'h0000_0100, "R3 unselected line kept");
        wr(4'd0, 32'h0000_0001);
        rd(4'd1, v);  chk(v, 32'h0, "R3 unselected line 0 kept");

        // R2/R13 reserved, lock, freeze
        rd(4'd7, v);  chk(v, 0, "R2 reserved reads 0");
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd6, v);  chk(v, 32'hFFFF_FFCF, "R2 reserved write ignored");
        rd(4'd4, v);  chk(v, 0, "R2 write-only reads 0");
        rd(4'd3, v);  chk(v, 0, "R13 lock status 0");
        wr(4'd15, 32'hDEAD_BEEF);
        rd(4'd15, v); chk(v, 32'hDEAD_BEEF, "R13 freeze readback");

        // R8 pin sampling
        pin_in = 32'hA5A5_1234;
        repeat (3) @(negedge clk);
        rd(4'd2, v);  chk(v, 32'hA5A5_1234, "R8 pin level");
        pin_in = 32'h0;

        // R9 event modes on lines 0,1,2,3,8,9
        wr(4'd0, 32'h0000_0001); wr(4'd1, 32'h0100_0000);
        wr(4'd0, 32'h0000_0002); wr(4'd1, 32'h0000_0000);
        wr(4'd0, 32'h0000_0004); wr(4'd1, 32'h0200_0000);
        wr(4'd0, 32'h0000_0008); wr(4'd1, 32'h0300_0000);
        wr(4'd0, 32'h0000_0100); wr(4'd1, 32'h0400_0000);
        wr(4'd0, 32'h0000_0200); wr(4'd1, 32'h0500_0000);
        repeat (4) @(negedge clk);
        rd(4'd11, v);
        pin_in = 32'h0000_0001;
        repeat (4) @(negedge clk);
        rd(4'd11, v); chk(v, 32'h0000_0009, "R9 rising and low level");
        pin_in = 32'h0000_0104;
        repeat (4) @(negedge clk);
        rd(4'd11, v); chk(v, 32'h0000_010C, "R9 both edge and high level");
        pin_in = 32'h0000_0202;
        repeat (4) @(negedge clk);
        rd(4'd11, v); chk(v, 32'h0000_010C, "R11 level kept through read cycle");
        pin_in = 32'h0000_0200;
        repeat (4) @(negedge clk);
        rd(4'd11, v); chk(v, 32'h0000_000A, "R9 falling, unused code silent");

        // R10/R12 interrupt mask
        wr(4'd8, 32'h0000_030F);
        rd(4'd10, v); chk(v, 32'h30F, "R10 enable");
        wr(4'd9, 32'h0000_0008);
        rd(4'd10, v); chk(v, 32'h307, "R10 disable");
        repeat (2) @(negedge clk);
        chk(irq, 0, "R12 pending bit masked");
        wr(4'd8, 32'h0000_0008);
        chk(irq, 1, "R12 pending bit unmasked");
        wr(4'd9, 32'hFFFF_FFFF);
        chk(irq, 0, "R12 all disabled");
        rd(4'd11, v); chk(v, 32'h0000_0008, "R11 status clears on read");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule